// File: doc/BRIEF.md
# Four-mode addressable bit latch

The block holds an eight-bit output word in which a single bit is chosen by a three-bit address. Two active-low controls pick one of four modes. In write mode the selected bit takes the data input and the others keep their values. In hold mode every bit keeps its value. In demultiplex mode the selected bit takes the data input and every other bit is cleared. In clear mode all bits go to zero. With the data input held high, demultiplex mode acts as a 3-to-8 decoder with active-high outputs.

A parameter picks one of two storage models. The level-sensitive model is transparent: while the enable is low, the addressed output follows the data input, and it keeps the last value it had when the enable rises. The clocked model applies the same mode rules on each rising clock edge and drives the outputs from flops, one cycle behind the inputs. This suits flows that avoid latches. Both models are cleared by an asynchronous active-low reset.

Top module: `addr_bit_latch`

## Requirements
- R1: The controls set the mode as follows: en_ni=0,clr_ni=1 is write; en_ni=1,clr_ni=1 is hold; en_ni=0,clr_ni=0 is demultiplex; en_ni=1,clr_ni=0 is clear.
- R2: In write mode, output bit addr_i takes data_i and all other bits keep their values.
- R3: In hold mode, all bits keep their values whatever data_i and addr_i do.
- R4: In demultiplex mode, bit addr_i takes data_i and the other bits are 0. With data_i=1 exactly one bit is set.
- R5: In clear mode, all bits are 0 whatever data_i and addr_i do.
- R6: A bit keeps the data value that was present on the last update before en_ni went high.
- R7: addr_i is binary with bit 0 least significant: address 0 selects q_o[0] and address 7 selects q_o[7].
- R8: clr_ni low with en_ni low does not clear the addressed bit, which still takes data_i.
- R9: In the clocked model (CLOCKED=1), q_o changes only after the rising clk_i edge that samples the controls.
- R10: In the level model (CLOCKED=0), q_o follows the inputs with no clock edge.
- R11: rst_ni low clears all bits at once, with no clock edge needed.
- R12: When addr_i moves while the block stays in write mode, the bit that was addressed before keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, used by the clocked model |
| rst_ni | input | 1 | Asynchronous active-low reset |
| data_i | input | 1 | Data bit |
| addr_i | input | 3 | Bit select, bit 0 least significant |
| en_ni | input | 1 | Active-low enable |
| clr_ni | input | 1 | Active-low clear control |
| q_o | output | 8 | Stored bits |

## Verification
The assertions check the clocked model on every cycle. After a hold cycle the word is unchanged. After a clear cycle it is zero. After a demultiplex cycle at most one bit is set, and the sampled address holds the sampled data. After a write cycle only the sampled bit may differ. The bench's scenarios are needed for the rest: the transparent timing of the level model, the one-cycle delay of the clocked model, the asynchronous reset in the middle of a cycle, a bit keeping its value when the address moves away, and decoding from a non-zero stored word. The bench compares both models with one reference word.

// File: rtl/alatch_pkg.sv
package alatch_pkg;
  typedef enum logic [1:0] {
    MODE_WRITE = 2'd0,
    MODE_HOLD  = 2'd1,
    MODE_DEMUX = 2'd2,
    MODE_CLEAR = 2'd3
  } mode_e;
endpackage

// File: rtl/alatch_mode_dec.sv
module alatch_mode_dec
  import alatch_pkg::*;
(
  input  logic  en_ni,
  input  logic  clr_ni,
  output mode_e mode_o
);
  always_comb begin
    unique case ({en_ni, clr_ni})
      2'b01:   mode_o = MODE_WRITE;
      2'b11:   mode_o = MODE_HOLD;
      2'b00:   mode_o = MODE_DEMUX;
      default: mode_o = MODE_CLEAR;
    endcase
  end
endmodule

// File: rtl/alatch_addr_dec.sv
module alatch_addr_dec #(
  parameter int WIDTH = 8,
  parameter int AW    = $clog2(WIDTH)
) (
  input  logic [AW-1:0]    addr_i,
  output logic [WIDTH-1:0] sel_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_sel
    assign sel_o[i] = (addr_i == AW'(i));
  end
endmodule

// File: rtl/alatch_next.sv
module alatch_next
  import alatch_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  mode_e            mode_i,
  input  logic [WIDTH-1:0] sel_i,
  input  logic             data_i,
  output logic [WIDTH-1:0] wen_o,
  output logic [WIDTH-1:0] nxt_o
);
  always_comb begin
    wen_o = '0;
    nxt_o = '0;
    unique case (mode_i)
      MODE_WRITE: begin
        wen_o = sel_i;
        nxt_o = sel_i & {WIDTH{data_i}};
      end
      MODE_DEMUX: begin
        wen_o = '1;
        nxt_o = sel_i & {WIDTH{data_i}};
      end
      MODE_CLEAR: wen_o = '1;
      default: ;
    endcase
  end
endmodule

// File: rtl/alatch_store.sv
module alatch_store #(
  parameter int WIDTH   = 8,
  parameter bit CLOCKED = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] wen_i,
  input  logic [WIDTH-1:0] nxt_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic bit_q;
    if (CLOCKED) begin : g_ff
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       bit_q <= 1'b0;
        else if (wen_i[i]) bit_q <= nxt_i[i];
      end
    end else begin : g_lat
      // transparent while write enabled; holds on release
      always_latch begin
        if (!rst_ni)       bit_q <= 1'b0;
        else if (wen_i[i]) bit_q <= nxt_i[i];
      end
    end
    assign q_o[i] = bit_q;
  end
endmodule

// File: rtl/addr_bit_latch.sv
module addr_bit_latch
  import alatch_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter bit CLOCKED = 1'b1,
  localparam int AW     = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             data_i,
  input  logic [AW-1:0]    addr_i,
  input  logic             en_ni,
  input  logic             clr_ni,
  output logic [WIDTH-1:0] q_o
);
  mode_e            mode;
  logic [WIDTH-1:0] sel, wen, nxt;

  alatch_mode_dec u_mode (
    .en_ni  (en_ni),
    .clr_ni (clr_ni),
    .mode_o (mode)
  );

  alatch_addr_dec #(.WIDTH(WIDTH), .AW(AW)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  alatch_next #(.WIDTH(WIDTH)) u_next (
    .mode_i (mode),
    .sel_i  (sel),
    .data_i (data_i),
    .wen_o  (wen),
    .nxt_o  (nxt)
  );

  alatch_store #(.WIDTH(WIDTH), .CLOCKED(CLOCKED)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wen_i  (wen),
    .nxt_i  (nxt),
    .q_o    (q_o)
  );
endmodule

// File: rtl/addr_bit_latch_chk.sv
module addr_bit_latch_chk #(
  parameter int WIDTH   = 8,
  parameter bit CLOCKED = 1'b1,
  parameter int AW      = $clog2(WIDTH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             data_i,
  input logic [AW-1:0]    addr_i,
  input logic             en_ni,
  input logic             clr_ni,
  input logic [WIDTH-1:0] q_o
);
  if (CLOCKED) begin : g_clk_props
    logic [WIDTH-1:0] one_hot_addr;
    assign one_hot_addr = WIDTH'(1) << addr_i;

    a_r3_hold_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_ni && clr_ni) |=> (q_o == $past(q_o)));

    a_r5_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_ni && !clr_ni) |=> (q_o == '0));

    a_r4_demux_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_ni && !clr_ni) |=> ($countones(q_o) <= 1));

    a_r8_demux_addr_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_ni && !clr_ni) |=> (q_o[$past(addr_i)] == $past(data_i)));

    a_r2_write_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_ni && clr_ni) |=> (q_o[$past(addr_i)] == $past(data_i)));

    a_r2_write_others: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_ni && clr_ni) |=> (((q_o ^ $past(q_o)) & ~$past(one_hot_addr)) == '0));
  end
endmodule

bind addr_bit_latch addr_bit_latch_chk #(.WIDTH(WIDTH), .CLOCKED(CLOCKED), .AW(AW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .data_i (data_i),
  .addr_i (addr_i),
  .en_ni  (en_ni),
  .clr_ni (clr_ni),
  .q_o    (q_o)
);

// File: tb/addr_bit_latch_bench.sv
module addr_bit_latch_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       data_i = 1'b0;
  logic [2:0] addr_i = 3'd0;
  logic       en_ni = 1'b1;
  logic       clr_ni = 1'b1;
  logic [7:0] q_clk, q_lvl;
  logic [7:0] ref_q = 8'h00;
  int total = 0;
  int bad = 0;

  always #10 clk_i = ~clk_i;

  addr_bit_latch #(.WIDTH(8), .CLOCKED(1'b1)) u_addr_bit_latch (
    .clk_i, .rst_ni, .data_i, .addr_i, .en_ni, .clr_ni, .q_o(q_clk)
  );
  addr_bit_latch #(.WIDTH(8), .CLOCKED(1'b0)) u_addr_bit_latch_lvl (
    .clk_i, .rst_ni, .data_i, .addr_i, .en_ni, .clr_ni, .q_o(q_lvl)
  );

  function automatic logic [7:0] model(logic [7:0] st, logic d, logic [2:0] a,
                                       logic en_n, logic clr_n);
    logic [7:0] hot;
    hot = 8'h01 << a;
    case ({en_n, clr_n})
      2'b01:   return d ? (st | hot) : (st & ~hot);
      2'b11:   return st;
      2'b00:   return d ? hot : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  // drive at negedge; level model settles at once, clocked after posedge
  task automatic step(string tag, logic d, logic [2:0] a, logic en_n, logic clr_n);
    logic [7:0] prev;
    @(negedge clk_i);
    prev = ref_q;
    data_i = d; addr_i = a; en_ni = en_n; clr_ni = clr_n;
    ref_q = model(prev, d, a, en_n, clr_n);
    #2;
    chk({tag, " R10 lvl"}, q_lvl, ref_q);
    chk({tag, " R9 pre-edge"}, q_clk, prev);
    @(posedge clk_i);
    #2;
    chk({tag, " R9 clk"}, q_clk, ref_q);
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #35;
    chk("R11 reset clk", q_clk, 8'h00);
    chk("R11 reset lvl", q_lvl, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R7 address mapping
    step("R7 addr0", 1'b1, 3'd0, 1'b0, 1'b1);
    chk("R7 bit0", q_lvl, 8'h01);
    step("R7 addr7", 1'b1, 3'd7, 1'b0, 1'b1);
    chk("R7 bit7", q_lvl, 8'h81);
    // R2 write one bit, others kept
    step("R2 write3", 1'b1, 3'd3, 1'b0, 1'b1);
    step("R2 clear0", 1'b0, 3'd0, 1'b0, 1'b1);
    chk("R2 word", q_clk, 8'h88);
    // R6 capture then release; data change after release ignored
    step("R6 d1", 1'b1, 3'd5, 1'b0, 1'b1);
    step("R6 release", 1'b0, 3'd5, 1'b1, 1'b1);
    chk("R6 kept", q_lvl, 8'ha8);
    // R3 hold ignores data and address
    step("R3 hold a", 1'b0, 3'd3, 1'b1, 1'b1);
    step("R3 hold b", 1'b1, 3'd1, 1'b1, 1'b1);
    chk("R3 word", q_clk, 8'ha8);
    // R12 moving address while enabled
    step("R12 on2", 1'b1, 3'd2, 1'b0, 1'b1);
    step("R12 move6", 1'b0, 3'd6, 1'b0, 1'b1);
    chk("R12 bit2 kept", q_lvl, 8'hac);
    // R4 demux from a non-zero word
    step("R4 demux4", 1'b1, 3'd4, 1'b0, 1'b0);
    chk("R4 only4", q_clk, 8'h10);
    for (int a = 0; a < 8; a++) begin
      step("R4 decode", 1'b1, 3'(a), 1'b0, 1'b0);
      chk("R4 decode onehot", q_lvl, 8'h01 << a);
    end
    // R8 conditional clear keeps addressed bit following data
    step("R8 prep", 1'b1, 3'd1, 1'b0, 1'b1);
    step("R8 d0", 1'b0, 3'd1, 1'b0, 1'b0);
    chk("R8 zero", q_clk, 8'h00);
    step("R8 d1", 1'b1, 3'd6, 1'b0, 1'b0);
    chk("R8 addressed", q_lvl, 8'h40);
    // R5 clear mode
    step("R5 fill", 1'b1, 3'd0, 1'b0, 1'b1);
    step("R5 clear", 1'b1, 3'd6, 1'b1, 1'b0);
    chk("R5 zero", q_clk, 8'h00);

    // R1 random mode mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] m;
      m = 4'($urandom_range(0, 9));
      step("R1 random", 1'($urandom), 3'($urandom),
           (m < 5) ? 1'b0 : (m < 8 ? 1'b1 : 1'($urandom)),
           (m < 2 || m > 7) ? 1'($urandom) : 1'b1);
    end

    // R11 asynchronous reset mid-cycle
    step("R11 fill", 1'b1, 3'd2, 1'b0, 1'b1);
    step("R11 hold", 1'b0, 3'd0, 1'b1, 1'b1);
    @(negedge clk_i);
    #3 rst_ni = 1'b0;
    #2;
    ref_q = 8'h00;
    chk("R11 async clk", q_clk, 8'h00);
    chk("R11 async lvl", q_lvl, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step("R11 after", 1'b1, 3'd4, 1'b0, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule